// File: doc/BRIEF.md
# Reversible-Cascade Synchronous Up Counter

This block is an N-bit binary up counter whose next-state logic is built only from reversible primitives. A one-bit enable and the present state form a wire set of N+1 lines. A fixed chain of controlled-NOT and multi-control Toffoli gates transforms that set in place, so the map from input lines to output lines is a bijection. Each gate flips the line of one state bit. Its controls are the enable and every lower state bit. The gates are applied from the most significant bit down to bit 0, so every upper gate sees the lower bits before they change.

The next-state lines are copied into a rising-edge state register. The register has a synchronous, active-high reset that clears it. The enable line leaves the chain unchanged and is exported as a garbage output. That line and the combinational next-state lines are both exposed on debug ports, so the reversible function can be inspected directly. All pins are plain control and status signals. There is no data stream and no handshake.

Top module: `rc_counter`

## Requirements
- R1: While `rst` is 1 at a rising edge of `clk`, `count` becomes 0 after that edge.
- R2: When `en` is 0 at a rising edge and `rst` is 0, `count` keeps its value.
- R3: When `en` is 1 at a rising edge and `rst` is 0, `count` becomes its previous value plus one, modulo 2^N.
- R4: With `en` at 1 and `count` at all ones (2^N-1), the next value of `count` is 0.
- R5: `dbg_next[0]` always equals `count[0]` XOR `en`.
- R6: For every bit i > 0, `dbg_next[i]` equals `count[i]` XOR (`en` AND `count[i-1]` AND ... AND `count[0]`), computed from the pre-update lower bits.
- R7: `dbg_garbage` always equals `en`, because the enable line passes through the cascade unchanged.
- R8: Over all 2^(N+1) combinations of (`en`, `count`), the pair (`dbg_garbage`, `dbg_next`) takes 2^(N+1) distinct values, which makes the cascade a bijection.
- R9: `count` changes only at a rising edge of `clk`. Between edges it stays stable while `en` toggles, and `dbg_next` follows `en` at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the state register updates on its rising edge |
| rst | input | 1 | Synchronous active-high clear of the state |
| en | input | 1 | Count enable; the count advances when this is 1 |
| count | output | N | Registered counter state |
| dbg_next | output | N | Combinational next-state lines from the cascade |
| dbg_garbage | output | 1 | Enable line as it leaves the cascade |

## Verification
The enable is driven in four patterns:
- **Pseudo-random:** mixes hold and advance cycles at every state. Any confusion between the two cases shows up here.
- **Continuous:** runs through the all-ones state several times, which exposes a wrong wrap or a broken carry chain into the top bit.
- **Hold run and mid-count reset:** separate the enable function from the clear.

Before each edge, the bench sets `en` to 0 and then to 1 and records both debug outputs each time. Walking this way through every state covers the whole input space of the cascade. This sweep detects a wrong control set on any gate and any lost bijectivity.

// File: rtl/rc_pkg.sv
package rc_pkg;
  // Position of the enable line inside the reversible wire set.
  localparam int unsigned RC_EN_LINE = 0;
  // Offset of state bit 0 inside the wire set.
  localparam int unsigned RC_Q_BASE  = 1;
endpackage

// File: rtl/rc_mct.sv
// Multi-control Toffoli gate: controls pass through, target flips when all
// controls are 1. With NC == 1 this is a controlled-NOT.
module rc_mct #(
  parameter int unsigned NC = 1
) (
  input  logic [NC-1:0] ctrl_i,
  input  logic          tgt_i,
  output logic [NC-1:0] ctrl_o,
  output logic          tgt_o
);
  assign ctrl_o = ctrl_i;
  assign tgt_o  = tgt_i ^ (&ctrl_i);
endmodule

// File: rtl/rc_cascade.sv
// In-place gate chain over {state, enable}; gate for the top bit first.
module rc_cascade
  import rc_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic         en_i,
  input  logic [N-1:0] q_i,
  output logic [N-1:0] nxt_o,
  output logic         garb_o
);
  localparam int unsigned W = N + 1;

  logic [N:0][W-1:0] stg;

  assign stg[0][RC_EN_LINE]          = en_i;
  assign stg[0][W-1:RC_Q_BASE]       = q_i;

  for (genvar k = 0; k < N; k++) begin : g_stage
    localparam int unsigned BIT = N - 1 - k;
    localparam int unsigned NC  = BIT + 1;
    rc_mct #(.NC(NC)) u_gate (
      .ctrl_i (stg[k][NC-1:0]),
      .tgt_i  (stg[k][NC]),
      .ctrl_o (stg[k+1][NC-1:0]),
      .tgt_o  (stg[k+1][NC])
    );
    if (NC + 1 <= W - 1) begin : g_pass
      assign stg[k+1][W-1:NC+1] = stg[k][W-1:NC+1];
    end
  end

  assign nxt_o  = stg[N][W-1:RC_Q_BASE];
  assign garb_o = stg[N][RC_EN_LINE];
endmodule

// File: rtl/rc_state_reg.sv
module rc_state_reg #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else     q_o <= d_i;
  end
endmodule

// File: rtl/rc_counter.sv
module rc_counter #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [N-1:0] count,
  output logic [N-1:0] dbg_next,
  output logic         dbg_garbage
);
  logic [N-1:0] nxt;
  logic         garb;

  rc_cascade #(.N(N)) u_cascade (
    .en_i   (en),
    .q_i    (count),
    .nxt_o  (nxt),
    .garb_o (garb)
  );

  // Feedback copy of each next-state line into the register.
  rc_state_reg #(.W(N)) u_state (
    .clk (clk),
    .rst (rst),
    .d_i (nxt),
    .q_o (count)
  );

  assign dbg_next    = nxt;
  assign dbg_garbage = garb;

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> count == '0); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(count)); // R2
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    en |=> count == N'($past(count) + 1'b1)); // R3
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (en && (&count)) |=> count == '0); // R4
  AST_LSB_LINE: assert property (@(posedge clk) disable iff (rst)
    dbg_next[0] == (count[0] ^ en)); // R5
  AST_GARB_EN: assert property (@(posedge clk) disable iff (rst)
    dbg_garbage == en); // R7
endmodule

// File: tb/rc_counter_tb.sv
module rc_counter_tb;
  localparam int N = 4;
  localparam int M = 1 << N;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [N-1:0] count, dbg_next;
  logic dbg_garbage;

  int checks = 0;
  int fails  = 0;
  int model  = 0;
  int cycles = 0;
  logic [7:0] lfsr = 8'hA5;
  bit seen [0:2*M-1];

  always #10 clk = ~clk;

  rc_counter #(.N(N)) u_dut (
    .clk(clk), .rst(rst), .en(en),
    .count(count), .dbg_next(dbg_next), .dbg_garbage(dbg_garbage)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected < 5000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_next(input int q, input bit e);
    return (q + (e ? 1 : 0)) % M;
  endfunction

  // Drive en at falling edge, check combinational lines, clock, check state.
  task automatic step(input bit e, input bit r);
    @(negedge clk);
    en = e; rst = r;
    #1;
    if (!r) begin
      chk("R5/R6", int'(dbg_next), exp_next(model, e));
      chk("R7", int'(dbg_garbage), int'(e));
    end
    @(posedge clk);
    model = r ? 0 : exp_next(model, e);
    #2;
    if (r)      chk("R1", int'(count), 0);
    else if (e) chk("R3", int'(count), model);
    else        chk("R2", int'(count), model);
  endtask

  initial begin
    step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    chk("R1 reset state", int'(count), 0);

    // Pseudo-random enable pattern
    for (int i = 0; i < 60; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[0], 1'b0);
    end

    // R9: toggling en between edges leaves count stable, dbg_next follows
    @(negedge clk);
    begin
      int held;
      held = int'(count);
      en = 1'b0; #2;
      chk("R9 next follows en=0", int'(dbg_next), exp_next(model, 1'b0));
      en = 1'b1; #2;
      chk("R9 next follows en=1", int'(dbg_next), exp_next(model, 1'b1));
      chk("R9 count stable", int'(count), held);
      en = 1'b0; #2;
    end

    // Continuous enable across several wraps (R4)
    for (int i = 0; i < 3 * M; i++) begin
      bit at_top;
      at_top = (model == M - 1);
      step(1'b1, 1'b0);
      if (at_top) chk("R4 wrap", int'(count), 0);
    end

    // Hold run
    for (int i = 0; i < 10; i++) step(1'b0, 1'b0);

    // Reset mid-count
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);

    // R8: sweep every (en, state) and record output pairs
    for (int i = 0; i < 2 * M; i++) seen[i] = 1'b0;
    for (int s = 0; s < M; s++) begin
      @(negedge clk);
      rst = 1'b0;
      for (int e = 0; e < 2; e++) begin
        en = e[0]; #1;
        chk("R6 sweep", int'(dbg_next), exp_next(model, e[0]));
        seen[{dbg_garbage, dbg_next}] = 1'b1;
      end
      @(posedge clk);
      model = exp_next(model, 1'b1);
      #2;
      chk("R3 sweep", int'(count), model);
    end
    begin
      int distinct;
      distinct = 0;
      for (int i = 0; i < 2 * M; i++) if (seen[i]) distinct++;
      chk("R8 bijection", distinct, 2 * M);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule